// File: doc/BRIEF.md
# Two-Port Shared Word Store with Collision Arbitration

This block is a 2048-word by 8-bit memory with two independent access ports, called left and right. Each port can reach every word. Each port has its own enable, its own read/write select, its own output enable, an 11-bit address, a write-data bus, and a registered read-data bus with a valid flag. Bidirectional data is modelled as separate input and output buses.

When both ports name the same word in the same cycle, an arbiter marks one of them busy in that same cycle. A busy port has its write dropped. Its read still returns data. Each port also owns a mailbox word at the top of the address space. When the opposite port writes that word, the owner's interrupt flag rises. The flag falls when the owner reads its own mailbox word.

A mode input selects between two roles. In generator mode the block arbitrates and drives its busy outputs. In follower mode it takes busy from outside and does no arbitration. Several blocks can then share one generator's busy decisions and act together as one wider word.

Top module: `twin_port_store`

## Requirements
- R1: Any of the 2048 words written through either port is returned on a later read through either port. Read data and its valid flag appear one clock after the read request.
- R2: Accesses from the two ports to different addresses in the same cycle both complete. Neither port is marked busy.
- R3: With `is_master`=1, a busy output is high only in a cycle where both ports are enabled and present equal addresses. A write from the busy port leaves the memory unchanged. A read from the busy port still returns the stored word one cycle later.
- R4: When both ports newly arrive at the same address in the same cycle, the right port is busy and the left is not. A port that held the address in the previous cycle keeps it, and the newcomer is busy. While both ports stay on that address, the same port remains busy. Both busy outputs are never high together.
- R5: An accepted (not busy) left-port write to address 0x7FF sets `r_irq` on the next clock. A right-port read of 0x7FF clears it on the next clock. If a set and a clear happen in the same cycle, the set wins.
- R6: An accepted right-port write to address 0x7FE sets `l_irq` on the next clock. A left-port read of 0x7FE clears it on the next clock.
- R7: The read-valid flag of a port is high exactly one cycle after that port had enable=1, write select=0 and output enable=1. Whenever the valid flag is low, the read data is 0.
- R8: With enable=0, a port writes nothing and produces no valid read data, whatever its other inputs are.
- R9: With `is_master`=0, both busy outputs stay 0. A port's write is dropped exactly when that port's busy input is 1. Reads to a shared address complete on both ports.
- R10: Synchronous active-high reset clears both interrupt flags, both valid flags and the arbitration history. The memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| is_master | input | 1 | 1: block arbitrates and drives busy; 0: busy taken from inputs |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port write select (1 write, 0 read) |
| l_oe | input | 1 | Left port output enable |
| l_addr | input | 11 | Left port word address |
| l_wdata | input | 8 | Left port write data |
| l_rdata | output | 8 | Left port read data, 0 when not valid |
| l_rvalid | output | 1 | Left port read data valid |
| l_busy_i | input | 1 | Left busy from an external generator (follower mode) |
| l_busy_o | output | 1 | Left busy decision (generator mode) |
| l_irq | output | 1 | Left mailbox interrupt flag |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port write select (1 write, 0 read) |
| r_oe | input | 1 | Right port output enable |
| r_addr | input | 11 | Right port word address |
| r_wdata | input | 8 | Right port write data |
| r_rdata | output | 8 | Right port read data, 0 when not valid |
| r_rvalid | output | 1 | Right port read data valid |
| r_busy_i | input | 1 | Right busy from an external generator (follower mode) |
| r_busy_o | output | 1 | Right busy decision (generator mode) |
| r_irq | output | 1 | Right mailbox interrupt flag |

## Verification
A wrong arbitration history shows up in the same cycle as a collision. The busy output names the wrong port, and the dropped write lands in memory, which the next read of that word exposes. A corrupted word or a bad read register is visible one cycle after the read request, because every address is written and read back from both ports. A mailbox flag that sets or clears on the wrong access differs at the port on the very next clock.

// File: rtl/tps_pkg.sv
package tps_pkg;

    localparam int unsigned ADDR_W = 11;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned NPORT  = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

    typedef struct packed {
        logic  en;
        logic  wr;
        logic  oe;
        addr_t addr;
        data_t wdata;
    } req_t;

    function automatic addr_t mbox_addr(side_e owner);
        return (owner == SIDE_R) ? addr_t'(DEPTH - 1) : addr_t'(DEPTH - 2);
    endfunction

    function automatic logic is_read(req_t r);
        return r.en & ~r.wr;
    endfunction

    function automatic logic is_show(req_t r);
        return r.en & ~r.wr & r.oe;
    endfunction

endpackage

// File: rtl/tps_arbiter.sv
module tps_arbiter
    import tps_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  req_t l_req,
    input  req_t r_req,
    output logic l_lose,
    output logic r_lose
);

    logic  prev_l_en, prev_r_en, prev_l_lose;
    addr_t prev_l_addr, prev_r_addr;
    logic  collide, l_cont, r_cont, left_out;

    always_comb begin
        collide  = l_req.en & r_req.en & (l_req.addr == r_req.addr);
        l_cont   = prev_l_en & (prev_l_addr == l_req.addr);
        r_cont   = prev_r_en & (prev_r_addr == r_req.addr);
        left_out = collide & r_cont & (~l_cont | prev_l_lose);
        l_lose   = left_out;
        r_lose   = collide & ~left_out;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_l_en   <= 1'b0;
            prev_r_en   <= 1'b0;
            prev_l_lose <= 1'b0;
            prev_l_addr <= '0;
            prev_r_addr <= '0;
        end else begin
            prev_l_en   <= l_req.en;
            prev_r_en   <= r_req.en;
            prev_l_lose <= l_lose;
            prev_l_addr <= l_req.addr;
            prev_r_addr <= r_req.addr;
        end
    end

    AST_LOSE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        (l_lose || r_lose) |-> (l_req.en && r_req.en && l_req.addr == r_req.addr)); // R3

    AST_STICKY_LOSER: assert property (@(posedge clk) disable iff (rst)
        (l_lose && l_req.en && r_req.en) |=>
        ((l_req.en && r_req.en && l_req.addr == $past(l_req.addr) && r_req.addr == $past(r_req.addr)) |-> !r_lose)); // R4

endmodule

// File: rtl/tps_mailbox.sv
module tps_mailbox
    import tps_pkg::*;
#(
    parameter side_e OWNER = SIDE_R
) (
    input  logic clk,
    input  logic rst,
    input  req_t own_req,
    input  req_t peer_req,
    input  logic peer_wr_ok,
    output logic irq_o
);

    localparam addr_t BOX = mbox_addr(OWNER);

    logic set_hit, clr_hit;

    always_comb begin
        set_hit = peer_wr_ok & (peer_req.addr == BOX);
        clr_hit = is_read(own_req) & (own_req.addr == BOX);
    end

    always_ff @(posedge clk) begin
        if (rst)          irq_o <= 1'b0;
        else if (set_hit) irq_o <= 1'b1;
        else if (clr_hit) irq_o <= 1'b0;
    end

    AST_BOX_SET: assert property (@(posedge clk) disable iff (rst)
        set_hit |=> irq_o); // R5, R6

    AST_BOX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_hit && !set_hit) |=> !irq_o); // R5, R6

endmodule

// File: rtl/tps_array.sv
module tps_array
    import tps_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  req_t  [NPORT-1:0]     req_i,
    input  logic  [NPORT-1:0]     wr_ok_i,
    output data_t [NPORT-1:0]     rdata_o,
    output logic  [NPORT-1:0]     rvalid_o
);

    data_t mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++) begin
            if (wr_ok_i[p]) mem[req_i[p].addr] <= req_i[p].wdata;
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_rd
        data_t q;
        logic  v;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
                v <= 1'b0;
            end else begin
                v <= is_show(req_i[g]);
                if (is_read(req_i[g])) q <= mem[req_i[g].addr];
            end
        end

        assign rvalid_o[g] = v;
        assign rdata_o[g]  = v ? q : '0;

        AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
            is_show(req_i[g]) |=> rvalid_o[g]); // R7

        AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
            !req_i[g].en |=> !rvalid_o[g]); // R8

        AST_WR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
            wr_ok_i[g] |-> (req_i[g].en && req_i[g].wr)); // R8
    end

endmodule

// File: rtl/twin_port_store.sv
module twin_port_store
    import tps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              is_master,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    input  logic              l_busy_i,
    output logic              l_busy_o,
    output logic              l_irq,
    input  logic              r_en,
    input  logic              r_wr,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid,
    input  logic              r_busy_i,
    output logic              r_busy_o,
    output logic              r_irq
);

    req_t               l_req, r_req;
    logic               l_lose, r_lose;
    logic               l_hold, r_hold;
    logic               l_wr_ok, r_wr_ok;
    data_t [NPORT-1:0]  rd_bus;
    logic  [NPORT-1:0]  rv_bus;

    assign l_req = {l_en, l_wr, l_oe, l_addr, l_wdata};
    assign r_req = {r_en, r_wr, r_oe, r_addr, r_wdata};

    tps_arbiter arb_i (
        .clk    (clk),
        .rst    (rst),
        .l_req  (l_req),
        .r_req  (r_req),
        .l_lose (l_lose),
        .r_lose (r_lose)
    );

    always_comb begin
        l_hold   = is_master ? l_lose : l_busy_i;
        r_hold   = is_master ? r_lose : r_busy_i;
        l_busy_o = is_master & l_lose;
        r_busy_o = is_master & r_lose;
        l_wr_ok  = l_en & l_wr & ~l_hold;
        r_wr_ok  = r_en & r_wr & ~r_hold;
    end

    tps_array mem_i (
        .clk      (clk),
        .rst      (rst),
        .req_i    ({r_req, l_req}),
        .wr_ok_i  ({r_wr_ok, l_wr_ok}),
        .rdata_o  (rd_bus),
        .rvalid_o (rv_bus)
    );

    assign l_rdata  = rd_bus[0];
    assign r_rdata  = rd_bus[1];
    assign l_rvalid = rv_bus[0];
    assign r_rvalid = rv_bus[1];

    tps_mailbox #(.OWNER(SIDE_R)) box_r_i (
        .clk        (clk),
        .rst        (rst),
        .own_req    (r_req),
        .peer_req   (l_req),
        .peer_wr_ok (l_wr_ok),
        .irq_o      (r_irq)
    );

    tps_mailbox #(.OWNER(SIDE_L)) box_l_i (
        .clk        (clk),
        .rst        (rst),
        .own_req    (l_req),
        .peer_req   (r_req),
        .peer_wr_ok (r_wr_ok),
        .irq_o      (l_irq)
    );

    AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (rst)
        !(l_busy_o && r_busy_o)); // R4

    AST_FOLLOWER_QUIET: assert property (@(posedge clk) disable iff (rst)
        !is_master |-> (!l_busy_o && !r_busy_o)); // R9

    AST_BUSY_NEEDS_SHARE: assert property (@(posedge clk) disable iff (rst)
        (l_busy_o || r_busy_o) |-> (l_en && r_en && l_addr == r_addr)); // R3

endmodule

// File: tb/twin_port_store_tb_top.sv
module twin_port_store_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic is_master = 1'b1;
    logic l_en = 0, l_wr = 0, l_oe = 0, l_busy_i = 0;
    logic r_en = 0, r_wr = 0, r_oe = 0, r_busy_i = 0;
    logic [10:0] l_addr = '0, r_addr = '0;
    logic [7:0]  l_wdata = '0, r_wdata = '0;
    logic [7:0]  l_rdata, r_rdata;
    logic        l_rvalid, r_rvalid, l_busy_o, r_busy_o, l_irq, r_irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    logic [7:0] exp_mem [2048];

    always #4 clk = ~clk;

    twin_port_store dut_i (
        .clk(clk), .rst(rst), .is_master(is_master),
        .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_busy_i(l_busy_i), .l_busy_o(l_busy_o), .l_irq(l_irq),
        .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_busy_i(r_busy_i), .r_busy_o(r_busy_o), .r_irq(r_irq)
    );

    function automatic logic [7:0] pat(int a);
        return 8'(((a * 29) ^ (a >> 8) ^ 'hC3) & 'hFF);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        l_en = 0; l_wr = 0; l_oe = 0;
        r_en = 0; r_wr = 0; r_oe = 0;
    endtask

    task automatic lset(logic wr, logic [10:0] a, logic [7:0] d);
        l_en = 1; l_wr = wr; l_oe = 1; l_addr = a; l_wdata = d;
    endtask

    task automatic rset(logic wr, logic [10:0] a, logic [7:0] d);
        r_en = 1; r_wr = wr; r_oe = 1; r_addr = a; r_wdata = d;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic read_left(logic [10:0] a, string tag);
        idle(); lset(0, a, 0); tick();
        chk(tag, l_rdata, exp_mem[a]);
        idle(); tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        #1;
        chk("R10 reset l_rvalid", l_rvalid, 0);
        chk("R10 reset r_rvalid", r_rvalid, 0);
        chk("R10 reset l_irq", l_irq, 0);
        chk("R10 reset r_irq", r_irq, 0);
        chk("R10 reset l_busy_o", l_busy_o, 0);
        tick();

        // R2: left writes even words, right writes odd words, same cycle
        for (int i = 0; i < 1024; i++) begin
            lset(1, 11'(2 * i), pat(2 * i));
            rset(1, 11'(2 * i + 1), pat(2 * i + 1));
            #1;
            if (l_busy_o || r_busy_o) chk("R2 no busy on distinct addr", 1, 0);
            exp_mem[2 * i] = pat(2 * i);
            exp_mem[2 * i + 1] = pat(2 * i + 1);
            tick();
        end
        idle();
        lset(1, 11'h7FF, 8'h5D); tick();
        exp_mem[11'h7FF] = 8'h5D;
        idle(); tick();
        chk("R5 left write 7FF sets r_irq", r_irq, 1);

        // R10: reset clears flags, memory kept
        rst = 1; tick(); tick(); rst = 0; #1;
        chk("R10 r_irq cleared", r_irq, 0);
        chk("R10 l_rvalid cleared", l_rvalid, 0);

        // R1: full readback, left ascending, right descending
        lset(0, 11'd0, 0); rset(0, 11'd2047, 0);
        for (int a = 1; a <= 2048; a++) begin
            tick();
            chk("R1 left readback", l_rdata, exp_mem[a - 1]);
            chk("R1 right readback", r_rdata, exp_mem[2048 - a]);
            chk("R7 left valid", l_rvalid, 1);
            chk("R7 right valid", r_rvalid, 1);
            if (a < 2048) begin
                lset(0, 11'(a), 0); rset(0, 11'(2047 - a), 0);
            end else idle();
        end
        tick();

        // R4: fresh collision, left wins
        lset(1, 11'h100, 8'hAA); rset(1, 11'h100, 8'h55); #1;
        chk("R4 fresh l_busy", l_busy_o, 0);
        chk("R4 fresh r_busy", r_busy_o, 1);
        tick(); exp_mem[11'h100] = 8'hAA;
        idle(); tick();
        read_left(11'h100, "R3 dropped right write");

        // R4: incumbent right keeps the word
        rset(0, 11'h200, 0); tick();
        lset(1, 11'h200, 8'h33); #1;
        chk("R4 incumbent l_busy", l_busy_o, 1);
        chk("R4 incumbent r_busy", r_busy_o, 0);
        tick();
        chk("R3 incumbent read data", r_rdata, exp_mem[11'h200]);
        idle(); tick();
        read_left(11'h200, "R3 busy write suppressed");

        // R3/R4: busy read still completes, loser stays loser
        lset(0, 11'h300, 0); rset(0, 11'h300, 0); #1;
        chk("R4 read collide r_busy", r_busy_o, 1);
        tick();
        chk("R3 busy read data", r_rdata, exp_mem[11'h300]);
        chk("R3 busy read valid", r_rvalid, 1);
        chk("R3 winner read data", l_rdata, exp_mem[11'h300]);
        #1;
        chk("R4 sticky r_busy", r_busy_o, 1);
        chk("R4 sticky l_busy", l_busy_o, 0);
        idle(); tick(); tick();

        // R5/R6 mailboxes
        lset(1, 11'h7FF, 8'h9C); tick(); exp_mem[11'h7FF] = 8'h9C;
        idle();
        chk("R5 set r_irq", r_irq, 1);
        chk("R6 l_irq untouched", l_irq, 0);
        rset(0, 11'h7FF, 0); tick();
        chk("R5 read data", r_rdata, 8'h9C);
        idle(); #1;
        chk("R5 clear r_irq", r_irq, 0);
        rset(1, 11'h7FE, 8'h61); tick(); exp_mem[11'h7FE] = 8'h61;
        idle();
        chk("R6 set l_irq", l_irq, 1);
        lset(0, 11'h7FE, 0); tick(); idle(); #1;
        chk("R6 clear l_irq", l_irq, 0);
        tick();
        rset(0, 11'h7FF, 0); tick();
        lset(1, 11'h7FF, 8'h0F); #1;
        chk("R5 busy write l_busy", l_busy_o, 1);
        tick(); idle(); #1;
        chk("R5 suppressed write no irq", r_irq, 0);
        tick();

        // R8 / R7: enable and output enable off
        l_en = 0; l_wr = 1; l_oe = 1; l_addr = 11'h500; l_wdata = 8'hEE; tick();
        chk("R8 en off valid", l_rvalid, 0);
        chk("R8 en off data", l_rdata, 0);
        idle(); tick();
        read_left(11'h500, "R8 en off no write");
        lset(0, 11'h500, 0); l_oe = 0; tick();
        chk("R7 oe off valid", l_rvalid, 0);
        chk("R7 oe off data", l_rdata, 0);
        idle(); tick();

        // R9: follower mode
        is_master = 0; l_busy_i = 1;
        lset(1, 11'h400, 8'h11); rset(1, 11'h401, 8'h22); #1;
        chk("R9 follower l_busy_o", l_busy_o, 0);
        tick(); exp_mem[11'h401] = 8'h22;
        l_busy_i = 0;
        lset(0, 11'h400, 0); rset(0, 11'h400, 0); #1;
        chk("R9 follower no arbitration", r_busy_o, 0);
        tick();
        chk("R9 left held write dropped", l_rdata, exp_mem[11'h400]);
        chk("R9 right shared read", r_rdata, exp_mem[11'h400]);
        idle(); tick();
        read_left(11'h401, "R9 right write accepted");
        is_master = 1;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule